// File: doc/BRIEF.md
# Status Register and Block Write Guard

This unit is the policy point of a serial nonvolatile memory. It keeps the status register: a write-enable latch, a pin-enable bit and a two-bit protected-block selector. It judges every array write and every status write that the serial front end is about to commit. Each request gets a registered one-cycle grant or deny pulse. A granted status write also updates the stored bits on the same edge. The serial protocol engine and the memory array sit outside. That engine supplies the committed requests, the write-enable and write-disable commands, the busy indication and the level of the active-low protect pin.

The unit has two resets. `rstN` is the initial reset and clears everything. `softRst` models a supply cycle. It clears only the volatile write-enable latch, so the protection settings survive it. While a status write has been started but not yet committed, the protect pin can cancel it. That cancel is shown on `cancelPulse`.

Top module: `wpGuard`

## Requirements
- R1: The status byte is {pinEn, 3'b000, blk[1:0], wen, busy} from bit 7 down to bit 0. After `rstN` it reads 00h, except that bit 0 always follows `busyIn` with no delay.
- R2: A `wenSet` cycle sets `wen` (bit 1) on the next edge. A `wenClr` cycle clears it.
- R3: An array write or status write requested while `wen` is 0 gets a one-cycle deny pulse on the next edge. The status byte does not change.
- R4: `blk` selects protection with ADDR_W=12: 00 protects nothing, 01 protects C00h-FFFh, 10 protects 800h-FFFh and 11 protects 000h-FFFh. An array write into a protected address is denied, and a write outside it is granted.
- R5: A granted status write loads data bit 7 into pinEn and data bits 3..2 into `blk`. Every other data bit is ignored.
- R6: A granted array write or status write clears `wen` on the same edge that raises the grant. A deny leaves `wen` unchanged.
- R7: With pinEn=1 and `wpPinN` low, a status write is denied. An array write is not affected by the pin.
- R8: With pinEn=0, `wpPinN` has no effect on status writes.
- R9: A cycle with `srPending` high, `wpPinN` low, pinEn=1 and `wen`=1 raises `cancelPulse` for exactly one cycle and clears `wen`. The pin has no effect when no status write is pending.
- R10: Any array write or status write requested while `busyIn` is 1 is denied.
- R11: `softRst` clears `wen` and keeps pinEn and `blk`.
- R12: Each request gives exactly one of grant or deny, as a pulse one cycle long, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Initial reset, active low, asynchronous |
| softRst | input | 1 | Supply-cycle reset, clears volatile state only |
| wenSet | input | 1 | Write-enable command strobe |
| wenClr | input | 1 | Write-disable command strobe |
| wrReq | input | 1 | Array write commit request |
| wrAddr | input | ADDR_W | Array write address |
| srReq | input | 1 | Status write commit request |
| srData | input | 8 | Status write data byte |
| srPending | input | 1 | Status write started, not yet committed |
| wpPinN | input | 1 | Protect pin level, active low |
| busyIn | input | 1 | Programming in progress |
| wrGrant | output | 1 | Array write granted |
| wrDeny | output | 1 | Array write refused |
| srGrant | output | 1 | Status write granted |
| srDeny | output | 1 | Status write refused |
| cancelPulse | output | 1 | Pending status write cancelled by the pin |
| statusByte | output | 8 | Status register readback |

## Verification
The pin cancel is the hardest case to reach. It needs pinEn set by an earlier granted status write. That write consumed the enable, so a fresh write-enable must follow, and then a pending cycle with the pin low. Random stimulus hits this chain rarely. A directed sequence therefore builds it step by step, and later random traffic crosses it with busy cycles and supply-cycle resets.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef struct packed {
    logic grantWr;
    logic denyWr;
    logic grantSr;
    logic denySr;
    logic cancel;
    logic setWen;
    logic clrWen;
  } ctlStrobes_t;

  localparam int STATUS_W = 8;
endpackage

// File: rtl/wpgProtect.sv
module wpgProtect #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        blk,
  output logic              isProt
);
  localparam int TOP = ADDR_W - 1;

  generate
    if (ADDR_W >= 2) begin : g_wide
      always_comb begin
        unique case (blk)
          2'b00: isProt = 1'b0;
          2'b01: isProt = (addr[TOP -: 2] == 2'b11);
          2'b10: isProt = addr[TOP];
          default: isProt = 1'b1;
        endcase
      end
    end else begin : g_narrow
      always_comb isProt = (blk == 2'b11) || (blk != 2'b00 && addr[0]);
    end
  endgenerate
endmodule

// File: rtl/wpgCtrl.sv
module wpgCtrl
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              softRst,
  input  logic              wenSet,
  input  logic              wenClr,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              srReq,
  input  logic              srPending,
  input  logic              wpPinN,
  input  logic              busyIn,
  input  logic              wen,
  input  logic              pinEn,
  input  logic [1:0]        blk,
  output ctlStrobes_t       stb
);
  logic isProt;
  logic blocked;
  logic pinLock;
  logic wrOk;
  logic srOk;

  wpgProtect #(.ADDR_W(ADDR_W)) u_prot (
    .addr  (wrAddr),
    .blk   (blk),
    .isProt(isProt)
  );

  always_comb begin
    blocked = busyIn || !wen;
    pinLock = pinEn && !wpPinN;
    wrOk    = wrReq && !blocked && !isProt;
    srOk    = srReq && !blocked && !pinLock;
    stb = '0;
    if (!softRst) begin
      stb.grantWr = wrOk;
      stb.denyWr  = wrReq && !wrOk;
      stb.grantSr = srOk;
      stb.denySr  = srReq && !srOk;
      stb.cancel  = srPending && !srReq && pinLock && wen;
      stb.setWen  = wenSet;
      stb.clrWen  = wenClr;
    end else begin
      stb.clrWen  = 1'b1;
    end
  end
endmodule

// File: rtl/wpgRegs.sv
module wpgRegs
  import wpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic [7:0]  srData,
  input  logic        busyIn,
  output logic        wen,
  output logic        pinEn,
  output logic [1:0]  blk,
  output logic        wrGrant,
  output logic        wrDeny,
  output logic        srGrant,
  output logic        srDeny,
  output logic        cancelPulse,
  output logic [STATUS_W-1:0] statusByte
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEn <= 1'b0;
      blk   <= 2'b00;
    end else if (stb.grantSr) begin
      pinEn <= srData[7];
      blk   <= srData[3:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wen <= 1'b0;
    end else if (stb.grantWr || stb.grantSr || stb.cancel || stb.clrWen) begin
      wen <= 1'b0;
    end else if (stb.setWen) begin
      wen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrGrant     <= 1'b0;
      wrDeny      <= 1'b0;
      srGrant     <= 1'b0;
      srDeny      <= 1'b0;
      cancelPulse <= 1'b0;
    end else begin
      wrGrant     <= stb.grantWr;
      wrDeny      <= stb.denyWr;
      srGrant     <= stb.grantSr;
      srDeny      <= stb.denySr;
      cancelPulse <= stb.cancel;
    end
  end

  assign statusByte = {pinEn, 3'b000, blk, wen, busyIn};
endmodule

// File: rtl/wpGuard.sv
module wpGuard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wenSet,
  input  logic              wenClr,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              srReq,
  input  logic [7:0]        srData,
  input  logic              srPending,
  input  logic              wpPinN,
  input  logic              busyIn,
  output logic              wrGrant,
  output logic              wrDeny,
  output logic              srGrant,
  output logic              srDeny,
  output logic              cancelPulse,
  output logic [7:0]        statusByte
);
  ctlStrobes_t stb;
  logic        wen;
  logic        pinEn;
  logic [1:0]  blk;

  wpgCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .softRst  (softRst),
    .wenSet   (wenSet),
    .wenClr   (wenClr),
    .wrReq    (wrReq),
    .wrAddr   (wrAddr),
    .srReq    (srReq),
    .srPending(srPending),
    .wpPinN   (wpPinN),
    .busyIn   (busyIn),
    .wen      (wen),
    .pinEn    (pinEn),
    .blk      (blk),
    .stb      (stb)
  );

  wpgRegs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .srData     (srData),
    .busyIn     (busyIn),
    .wen        (wen),
    .pinEn      (pinEn),
    .blk        (blk),
    .wrGrant    (wrGrant),
    .wrDeny     (wrDeny),
    .srGrant    (srGrant),
    .srDeny     (srDeny),
    .cancelPulse(cancelPulse),
    .statusByte (statusByte)
  );
endmodule

// File: rtl/wpGuardChk.sv
module wpGuardChk (
  input logic       clk,
  input logic       rstN,
  input logic       busyIn,
  input logic       wpPinN,
  input logic       wrGrant,
  input logic       wrDeny,
  input logic       srGrant,
  input logic       srDeny,
  input logic       cancelPulse,
  input logic [7:0] statusByte
);
  p_grant_needs_wen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrGrant || srGrant) |-> $past(statusByte[1]));

  p_grant_clears_wen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrGrant || srGrant) |-> !statusByte[1]);

  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(wrGrant && wrDeny) && !(srGrant && srDeny));

  p_cancel_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |=> !cancelPulse);

  p_cancel_clears_wen_r9: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |-> !statusByte[1]);

  p_nv_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !srGrant |-> $stable({statusByte[7], statusByte[3:2]}));

  p_pin_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    srGrant |-> !($past(statusByte[7]) && !$past(wpPinN)));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrGrant || srGrant) |-> !$past(busyIn));

  always_comb begin
    p_zero_bits_r1: assert (statusByte[6:4] == 3'b000);
  end
endmodule

bind wpGuard wpGuardChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busyIn     (busyIn),
  .wpPinN     (wpPinN),
  .wrGrant    (wrGrant),
  .wrDeny     (wrDeny),
  .srGrant    (srGrant),
  .srDeny     (srDeny),
  .cancelPulse(cancelPulse),
  .statusByte (statusByte)
);

// File: tb/wpGuard_bench.sv
module wpGuard_bench;
  localparam int AW = 12;
  localparam int OP_IDLE = 0, OP_WREN = 1, OP_WRDI = 2, OP_WR = 3,
                 OP_SR = 4, OP_PEND = 5, OP_SOFT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0, wenSet = 1'b0, wenClr = 1'b0, wrReq = 1'b0;
  logic srReq = 1'b0, srPending = 1'b0, wpPinN = 1'b1, busyIn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] srData = '0;
  logic wrGrant, wrDeny, srGrant, srDeny, cancelPulse;
  logic [7:0] statusByte;

  int nChecks = 0;
  int nFails = 0;

  logic mWen = 1'b0;
  logic mPinEn = 1'b0;
  logic [1:0] mBlk = 2'b00;

  always #2.5 clk = ~clk;

  wpGuard #(.ADDR_W(AW)) u_wpGuard (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wenSet(wenSet), .wenClr(wenClr),
    .wrReq(wrReq), .wrAddr(wrAddr), .srReq(srReq), .srData(srData),
    .srPending(srPending), .wpPinN(wpPinN), .busyIn(busyIn),
    .wrGrant(wrGrant), .wrDeny(wrDeny), .srGrant(srGrant), .srDeny(srDeny),
    .cancelPulse(cancelPulse), .statusByte(statusByte)
  );

  function automatic logic protAt(input logic [1:0] b, input logic [AW-1:0] a);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a[AW-1:AW-2] == 2'b11;
      2'b10: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] expStatus(input logic bz);
    return {mPinEn, 3'b000, mBlk, mWen, bz};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %013b expected %013b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input int op, input logic [AW-1:0] a,
                      input logic [7:0] d, input logic wp, input logic bz);
    logic eGW, eDW, eGS, eDS, eC, blk;
    eGW = 0; eDW = 0; eGS = 0; eDS = 0; eC = 0;
    softRst = (op == OP_SOFT); wenSet = (op == OP_WREN); wenClr = (op == OP_WRDI);
    wrReq = (op == OP_WR); srReq = (op == OP_SR); srPending = (op == OP_PEND);
    wrAddr = a; srData = d; wpPinN = wp; busyIn = bz;
    blk = bz || !mWen;
    case (op)
      OP_WREN: mWen = 1'b1;
      OP_WRDI, OP_SOFT: mWen = 1'b0;
      OP_WR: begin
        eGW = !blk && !protAt(mBlk, a); eDW = !eGW;
        if (eGW) mWen = 1'b0;
      end
      OP_SR: begin
        eGS = !blk && !(mPinEn && !wp); eDS = !eGS;
        if (eGS) begin mPinEn = d[7]; mBlk = d[3:2]; mWen = 1'b0; end
      end
      OP_PEND: begin
        eC = !wp && mPinEn && mWen;
        if (eC) mWen = 1'b0;
      end
      default: ;
    endcase
    @(negedge clk);
    check(tag, {wrGrant, wrDeny, srGrant, srDeny, cancelPulse, statusByte},
               {eGW, eDW, eGS, eDS, eC, expStatus(bz)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset", {wrGrant, wrDeny, srGrant, srDeny, cancelPulse, statusByte}, 13'd0);
    step("R1 busy bit", OP_IDLE, '0, 8'h00, 1, 1);
    // R3: refused without enable
    step("R3 write wen0", OP_WR, 12'h010, 8'h00, 1, 0);
    step("R3 wrsr wen0", OP_SR, '0, 8'h8C, 1, 0);
    // R2 / R5 / R6
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R5 R6 wrsr masked", OP_SR, '0, 8'h7F, 1, 0);
    step("R2 wren again", OP_WREN, '0, 8'h00, 1, 0);
    step("R4 blk11 addr0", OP_WR, 12'h000, 8'h00, 1, 0);
    step("R6 deny keeps wen wrsr", OP_SR, '0, 8'h84, 1, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R4 blk01 C00", OP_WR, 12'hC00, 8'h00, 1, 0);
    step("R4 blk01 BFF", OP_WR, 12'hBFF, 8'h00, 1, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R7 pin blocks wrsr", OP_SR, '0, 8'h00, 0, 0);
    step("R7 pin ignored for write", OP_WR, 12'h000, 8'h00, 0, 0);
    step("R9 idle pin low no pending", OP_IDLE, '0, 8'h00, 0, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R9 cancel", OP_PEND, '0, 8'h00, 0, 0);
    step("R9 single pulse", OP_PEND, '0, 8'h00, 0, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R10 busy write", OP_WR, 12'h001, 8'h00, 1, 1);
    step("R10 busy wrsr", OP_SR, '0, 8'h00, 1, 1);
    step("R11 soft reset", OP_SOFT, '0, 8'h00, 1, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R2 wrdi", OP_WRDI, '0, 8'h00, 1, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R5 set blk10 pin off", OP_SR, '0, 8'h08, 1, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R4 blk10 800", OP_WR, 12'h800, 8'h00, 1, 0);
    step("R4 blk10 7FF", OP_WR, 12'h7FF, 8'h00, 1, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R8 pin off wrsr", OP_SR, '0, 8'h00, 0, 0);
    step("R2 wren", OP_WREN, '0, 8'h00, 1, 0);
    step("R4 blk00 FFF", OP_WR, 12'hFFF, 8'h00, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      int op;
      r = int'($urandom_range(0, 99));
      if (r < 25) op = OP_WREN;
      else if (r < 30) op = OP_WRDI;
      else if (r < 55) op = OP_WR;
      else if (r < 72) op = OP_SR;
      else if (r < 87) op = OP_PEND;
      else if (r < 91) op = OP_SOFT;
      else op = OP_IDLE;
      step("R12 random", op, AW'($urandom), 8'($urandom),
           ($urandom_range(0, 2) != 0), ($urandom_range(0, 7) == 0));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule